// File: doc/BRIEF.md
# JTAG Chain IDCODE Checker

This block is a small JTAG master. It drives TCK, TMS and TDI into a daisy chain of TAP controllers and samples the TDO returned from the far end of the chain. On a start request it brings every TAP to Test-Logic-Reset. It then performs one instruction scan, which places the IDCODE opcode into a single chosen target and the all-ones BYPASS opcode into every other device. A data scan follows, and the block reads back the target's 32-bit identification word.

Four padding counts place the target inside the chain. The IR padding gives the number of bypass instruction bits that belong to devices between the target and TDO (`pad_ir_tdo`) and between TDI and the target (`pad_ir_tdi`). The DR padding gives the matching counts of one-bit bypass registers (`pad_dr_tdo`, `pad_dr_tdi`). All four are zero for a chain of one device. Bits that arrive from devices on the TDO side of the target are discarded before capture starts.

At the end of a run the block reports two results. The first tells whether the target's instruction-register capture pattern arrived intact. The second tells whether the identification word equals the expected value supplied at start. TCK is derived from the system clock through a programmable divider.

Top module: `jtag_idchk`

## Requirements
- R1: After reset `busy`, `done`, `ir_ok`, `id_match` and `tck` are 0 and `tms` is 1, and TCK stays low while no run is active.
- R2: Every run begins with five TCK rising edges with TMS high, followed by one rising edge with TMS low.
- R3: The instruction scan shifts, in order, `pad_ir_tdo` ones, then the 10-bit IDCODE opcode 1001101000 (leftmost character first, value 10'h059 with bit 0 shifted first), then `pad_ir_tdi` ones. The scan leaves Shift-IR through Pause-IR and returns to Run-Test/Idle with TMS 1,1,0. After the run the target holds 10'h059 and every other device holds 10'h3FF.
- R4: The data scan shifts `pad_dr_tdo + 32 + pad_dr_tdi` ones. TMS is high only on the last bit of each shift. With n_ir = `pad_ir_tdo + 10 + pad_ir_tdi` and n_dr = `pad_dr_tdo + 32 + pad_dr_tdi`, one run makes exactly 19 + n_ir + n_dr TCK rising edges.
- R5: Each TCK high phase and each TCK low phase lasts `div + 1` clock cycles. TMS and TDI change only while TCK is low.
- R6: TDO is sampled at TCK rising edges. The first `pad_ir_tdo` bits of the IR shift and the first `pad_dr_tdo` bits of the DR shift are discarded before capture begins.
- R7: `ir_ok` is 1 only when the 10 captured target IR bits, in arrival order, are 0,1,0,1,0,1,0,1,0,1 (value 10'h2AA with the first bit at bit 0).
- R8: `id_match` is 1 only when the 32 captured DR bits, with the first arrival at bit 0, equal the `exp_id` latched at start.
- R9: `busy` rises the cycle after an accepted `start` and falls at the final TCK falling edge. `done` is a one-cycle pulse that follows, with `busy` low. A `start` while busy is ignored, including its new configuration.
- R10: `div` must be at least `TDO_STAGES` (2 by default) when a run starts. The minimum value still returns correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle) |
| div | input | DIVW | TCK half-period minus one, in clk cycles |
| pad_ir_tdo | input | PADW | Bypass IR bits between target and TDO |
| pad_ir_tdi | input | PADW | Bypass IR bits between TDI and target |
| pad_dr_tdo | input | PADW | Bypass DR bits between target and TDO |
| pad_dr_tdi | input | PADW | Bypass DR bits between TDI and target |
| exp_id | input | ID_LEN | Expected identification word |
| tdo | input | 1 | Serial data from the end of the chain |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select to the chain |
| tdi | output | 1 | Serial data into the chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ir_ok | output | 1 | Target IR capture pattern correct |
| id_match | output | 1 | Identification word equals `exp_id` |

## Verification
If the sequencer's state or bit counter is wrong, the TMS pattern goes wrong. That shows up within one TCK period as a wrong rising-edge count or as the wrong opcode left in a chain device. A capture window shifted by even one bit misaligns the identification word or the IR pattern, and that fault becomes visible at the single `done` pulse. Divider or edge-placement faults appear at the very first TCK phase, as a wrong phase length or as TMS/TDI moving while TCK is high.

// File: rtl/jic_pkg.sv
package jic_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_RST, S_IRHD, S_IRSH, S_IRPS, S_IRTL, S_DRHD, S_DRSH, S_DRTL, S_FIN
   } seq_st_t;

   // last step index of the fixed TMS walks between scans
   localparam int IR_HEAD_LAST = 3;  // RTI -> Shift-IR : 1,1,0,0
   localparam int IR_TAIL_LAST = 2;  // Pause-IR -> RTI : 1,1,0
   localparam int DR_HEAD_LAST = 2;  // RTI -> Shift-DR : 1,0,0
   localparam int DR_TAIL_LAST = 1;  // Exit1-DR -> RTI : 1,0
endpackage

// File: rtl/jic_tck_gen.sv
module jic_tck_gen #(
   parameter int DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] div,
   output logic            tck,
   output logic            rise,
   output logic            fall
);
   logic [DIVW-1:0] cnt;
   logic            wrap;

   assign wrap = run && (cnt == div);
   assign rise = wrap && !tck;
   assign fall = wrap && tck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         tck <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         tck <= ~tck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_TCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tck); // R5
endmodule

// File: rtl/jic_seq.sv
module jic_seq
   import jic_pkg::*;
#(
   parameter int PADW    = 8,
   parameter int CW      = 11,
   parameter int IR_LEN  = 10,
   parameter int ID_LEN  = 32,
   parameter int RST_CYC = 5,
   parameter logic [IR_LEN-1:0] OPC = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            rise,
   input  logic            fall,
   input  logic [PADW-1:0] pad_ir_tdo,
   input  logic [PADW-1:0] pad_ir_tdi,
   input  logic [PADW-1:0] pad_dr_tdo,
   input  logic [PADW-1:0] pad_dr_tdi,
   output logic            tms,
   output logic            tdi,
   output logic            busy,
   output logic            fin,
   output logic            ir_win,
   output logic            dr_win
);
   localparam int IRB = (IR_LEN > 1) ? $clog2(IR_LEN) : 1;
   localparam int OPN = 1 << IRB;
   localparam logic [OPN-1:0] OPC_X = OPN'(OPC);

   seq_st_t         st, nxt;
   logic [CW-1:0]   cnt, lim, n_ir, n_dr, ir_off, dr_off;
   logic [PADW-1:0] irt_q, iri_q, drt_q, dri_q;
   logic            tms_d, tdi_d;

   assign n_ir   = CW'(irt_q) + CW'(iri_q) + CW'(IR_LEN);
   assign n_dr   = CW'(drt_q) + CW'(dri_q) + CW'(ID_LEN);
   assign ir_off = cnt - CW'(irt_q);
   assign dr_off = cnt - CW'(drt_q);
   assign ir_win = (st == S_IRSH) && (cnt >= CW'(irt_q)) && (ir_off < CW'(IR_LEN));
   assign dr_win = (st == S_DRSH) && (cnt >= CW'(drt_q)) && (dr_off < CW'(ID_LEN));

   always_comb begin
      lim   = '0;
      nxt   = S_IDLE;
      tms_d = 1'b1;
      tdi_d = 1'b1;
      unique case (st)
         S_RST:  begin lim = CW'(RST_CYC);      nxt = S_IRHD; tms_d = (cnt != lim); end
         S_IRHD: begin lim = CW'(IR_HEAD_LAST); nxt = S_IRSH; tms_d = (cnt < CW'(2)); end
         S_IRSH: begin
            lim   = n_ir - CW'(1);
            nxt   = S_IRPS;
            tms_d = (cnt == lim);
            if (ir_win) tdi_d = OPC_X[ir_off[IRB-1:0]];
         end
         S_IRPS: begin lim = '0;                nxt = S_IRTL; tms_d = 1'b0; end
         S_IRTL: begin lim = CW'(IR_TAIL_LAST); nxt = S_DRHD; tms_d = (cnt < CW'(2)); end
         S_DRHD: begin lim = CW'(DR_HEAD_LAST); nxt = S_DRSH; tms_d = (cnt == '0); end
         S_DRSH: begin lim = n_dr - CW'(1);     nxt = S_DRTL; tms_d = (cnt == lim); end
         S_DRTL: begin lim = CW'(DR_TAIL_LAST); nxt = S_FIN;  tms_d = (cnt == '0); end
         default: begin lim = '0; nxt = S_IDLE; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         cnt   <= '0;
         busy  <= 1'b0;
         fin   <= 1'b0;
         tms   <= 1'b1;
         tdi   <= 1'b1;
         irt_q <= '0;
         iri_q <= '0;
         drt_q <= '0;
         dri_q <= '0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            st    <= S_RST;
            cnt   <= '0;
            busy  <= 1'b1;
            tms   <= 1'b1;
            tdi   <= 1'b1;
            irt_q <= pad_ir_tdo;
            iri_q <= pad_ir_tdi;
            drt_q <= pad_dr_tdo;
            dri_q <= pad_dr_tdi;
         end else if (busy) begin
            if (rise) begin
               if (cnt == lim) begin
                  cnt <= '0;
                  st  <= nxt;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            if (fall) begin
               if (st == S_FIN) begin
                  busy <= 1'b0;
                  fin  <= 1'b1;
                  st   <= S_IDLE;
                  tms  <= 1'b1;
                  tdi  <= 1'b1;
               end else begin
                  tms <= tms_d;
                  tdi <= tdi_d;
               end
            end
         end
      end
   end

   AST_RST_TMS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && st == S_RST && cnt < CW'(RST_CYC)) |-> tms); // R2
   AST_IR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && st == S_IRSH) |-> (tms == (cnt == lim))); // R3
   AST_DR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && st == S_DRSH) |-> (tms == (cnt == lim)) && tdi); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= lim)); // R4
endmodule

// File: rtl/jic_cap.sv
module jic_cap #(
   parameter int IR_LEN = 10,
   parameter int ID_LEN = 32,
   parameter logic [IR_LEN-1:0] CAP_EXP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              rise,
   input  logic              ir_win,
   input  logic              dr_win,
   input  logic              tdo_s,
   input  logic              fin,
   input  logic [ID_LEN-1:0] exp_id,
   output logic              done,
   output logic              ir_ok,
   output logic              id_match
);
   logic [IR_LEN-1:0] ir_sh;
   logic [ID_LEN-1:0] id_sh, exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh    <= '0;
         id_sh    <= '0;
         exp_q    <= '0;
         done     <= 1'b0;
         ir_ok    <= 1'b0;
         id_match <= 1'b0;
      end else begin
         done <= fin;
         if (go) begin
            ir_sh    <= '0;
            id_sh    <= '0;
            exp_q    <= exp_id;
            ir_ok    <= 1'b0;
            id_match <= 1'b0;
         end else begin
            if (rise && ir_win) ir_sh <= {tdo_s, ir_sh[IR_LEN-1:1]};
            if (rise && dr_win) id_sh <= {tdo_s, id_sh[ID_LEN-1:1]};
            if (fin) begin
               ir_ok    <= (ir_sh == CAP_EXP);
               id_match <= (id_sh == exp_q);
            end
         end
      end
   end

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && !fin) |=> ($stable(ir_ok) && $stable(id_match))); // R8
   AST_WIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ir_win && dr_win)); // R6
endmodule

// File: rtl/jtag_idchk.sv
module jtag_idchk #(
   parameter int DIVW       = 8,
   parameter int PADW       = 8,
   parameter int IR_LEN     = 10,
   parameter int ID_LEN     = 32,
   parameter int RST_CYC    = 5,
   parameter int TDO_STAGES = 2,
   parameter logic [IR_LEN-1:0] IDC_OPC = 10'h059,
   parameter logic [IR_LEN-1:0] CAP_EXP = 10'h2AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DIVW-1:0]   div,
   input  logic [PADW-1:0]   pad_ir_tdo,
   input  logic [PADW-1:0]   pad_ir_tdi,
   input  logic [PADW-1:0]   pad_dr_tdo,
   input  logic [PADW-1:0]   pad_dr_tdi,
   input  logic [ID_LEN-1:0] exp_id,
   input  logic              tdo,
   output logic              tck,
   output logic              tms,
   output logic              tdi,
   output logic              busy,
   output logic              done,
   output logic              ir_ok,
   output logic              id_match
);
   localparam int CW = $clog2(2 * (1 << PADW) + ID_LEN + IR_LEN);

   if (IR_LEN < 2)                      $error("IR_LEN too small");
   if (ID_LEN < 1)                      $error("ID_LEN too small");
   if (RST_CYC < 5)                     $error("RST_CYC below five");
   if (TDO_STAGES < 0 || TDO_STAGES > 3) $error("TDO_STAGES out of range");
   if (DIVW < 2)                        $error("DIVW too small");

   logic            go, fin, rise, fall, ir_win, dr_win, tdo_s;
   logic [DIVW-1:0] div_q;

   assign go = start && !busy && !fin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  div_q <= '0;
      else if (go) div_q <= div;
   end

   if (TDO_STAGES == 0) begin : g_tdo_direct
      assign tdo_s = tdo;
   end else begin : g_tdo_sync
      logic [TDO_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= (sr << 1) | TDO_STAGES'(tdo);
      end
      assign tdo_s = sr[TDO_STAGES-1];
   end

   jic_tck_gen #(.DIVW(DIVW)) u_tck (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
      .tck(tck), .rise(rise), .fall(fall)
   );

   jic_seq #(
      .PADW(PADW), .CW(CW), .IR_LEN(IR_LEN), .ID_LEN(ID_LEN),
      .RST_CYC(RST_CYC), .OPC(IDC_OPC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .rise(rise), .fall(fall),
      .pad_ir_tdo(pad_ir_tdo), .pad_ir_tdi(pad_ir_tdi),
      .pad_dr_tdo(pad_dr_tdo), .pad_dr_tdi(pad_dr_tdi),
      .tms(tms), .tdi(tdi), .busy(busy), .fin(fin),
      .ir_win(ir_win), .dr_win(dr_win)
   );

   jic_cap #(.IR_LEN(IR_LEN), .ID_LEN(ID_LEN), .CAP_EXP(CAP_EXP)) u_cap (
      .clk(clk), .rst_n(rst_n), .go(go), .rise(rise),
      .ir_win(ir_win), .dr_win(dr_win), .tdo_s(tdo_s), .fin(fin),
      .exp_id(exp_id), .done(done), .ir_ok(ir_ok), .id_match(id_match)
   );

   AST_TMS_TDI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      tck |-> ($stable(tms) && $stable(tdi))); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (div >= DIVW'(TDO_STAGES))); // R10
endmodule

// File: tb/jtag_idchk_tb.sv
module jic_tap_model #(
   parameter logic [31:0] ID = 32'h1
) (
   input  logic       tck,
   input  logic       tms,
   input  logic       tdi,
   input  logic       cap_bad,
   output logic       tdo,
   output logic [9:0] ir
);
   typedef enum logic [3:0] {
      TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
      SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR
   } tap_t;
   localparam logic [9:0] OPC = 10'h059;

   tap_t        st = TLR;
   logic [9:0]  irsh = '0;
   logic [31:0] drsh = '0;
   logic        byp = 1'b0;

   initial begin
      ir  = OPC;
      tdo = 1'b0;
   end

   always @(posedge tck) begin
      case (st)
         TLR:  ir <= OPC;
         CIR:  irsh <= cap_bad ? 10'h155 : 10'h2AA;
         SHIR: irsh <= {tdi, irsh[9:1]};
         UIR:  ir <= irsh;
         CDR:  begin drsh <= ID; byp <= 1'b0; end
         SHDR: begin drsh <= {tdi, drsh[31:1]}; byp <= tdi; end
         default: ;
      endcase
      case (st)
         TLR:  st <= tms ? TLR  : RTI;
         RTI:  st <= tms ? SDR  : RTI;
         SDR:  st <= tms ? SIR  : CDR;
         CDR:  st <= tms ? E1DR : SHDR;
         SHDR: st <= tms ? E1DR : SHDR;
         E1DR: st <= tms ? UDR  : PDR;
         PDR:  st <= tms ? E2DR : PDR;
         E2DR: st <= tms ? UDR  : SHDR;
         UDR:  st <= tms ? SDR  : RTI;
         SIR:  st <= tms ? TLR  : CIR;
         CIR:  st <= tms ? E1IR : SHIR;
         SHIR: st <= tms ? E1IR : SHIR;
         E1IR: st <= tms ? UIR  : PIR;
         PIR:  st <= tms ? E2IR : PIR;
         E2IR: st <= tms ? UIR  : SHIR;
         default: st <= tms ? SDR : RTI;
      endcase
   end

   always @(negedge tck) begin
      if (st == SHIR)      tdo <= irsh[0];
      else if (st == SHDR) tdo <= (ir == OPC) ? drsh[0] : byp;
      else                 tdo <= 1'b0;
   end
endmodule

module jtag_idchk_tb;
   localparam logic [31:0] ID0 = 32'h1110_1093;
   localparam logic [31:0] ID1 = 32'h2220_20DD;
   localparam logic [31:0] ID2 = 32'h3330_3041;
   localparam logic [31:0] ID3 = 32'h4440_40F5;
   localparam logic [9:0]  OPC = 10'h059;
   localparam logic [9:0]  BYP = 10'h3FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  div = 8'd2;
   logic [7:0]  pirt = '0, piri = '0, pdrt = '0, pdri = '0;
   logic [31:0] exp_id = '0;
   logic        tdo, tck, tms, tdi, busy, done, ir_ok, id_match;
   logic        sel_b = 1'b0;
   logic [3:0]  cbad = '0;
   logic        t0, t1, t2, t3;
   logic [9:0]  ir0, ir1, ir2, ir3;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   jtag_idchk u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .div(div),
      .pad_ir_tdo(pirt), .pad_ir_tdi(piri), .pad_dr_tdo(pdrt), .pad_dr_tdi(pdri),
      .exp_id(exp_id), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi),
      .busy(busy), .done(done), .ir_ok(ir_ok), .id_match(id_match)
   );

   // chain A: TDI -> d0 -> d1 -> d2 -> TDO ; chain B: single d3
   jic_tap_model #(.ID(ID0)) u_d0 (.tck(tck), .tms(tms), .tdi(tdi), .cap_bad(cbad[0]), .tdo(t0), .ir(ir0));
   jic_tap_model #(.ID(ID1)) u_d1 (.tck(tck), .tms(tms), .tdi(t0),  .cap_bad(cbad[1]), .tdo(t1), .ir(ir1));
   jic_tap_model #(.ID(ID2)) u_d2 (.tck(tck), .tms(tms), .tdi(t1),  .cap_bad(cbad[2]), .tdo(t2), .ir(ir2));
   jic_tap_model #(.ID(ID3)) u_d3 (.tck(tck), .tms(tms), .tdi(tdi), .cap_bad(cbad[3]), .tdo(t3), .ir(ir3));
   assign tdo = sel_b ? t3 : t2;

   // monitors
   int         rise_n = 0;
   logic [5:0] tms_log = '0;
   always @(posedge tck) begin
      if (rise_n < 6) tms_log[rise_n] = tms;
      rise_n = rise_n + 1;
   end

   int   hp_cnt = 0, hp_bad = 0, hi_viol = 0, dv_cur = 2;
   bit   hp_seen = 0;
   logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b1;
   always @(negedge clk) begin
      hp_cnt = hp_cnt + 1;
      if (tck !== p_tck) begin
         if (hp_seen && hp_cnt != dv_cur + 1) hp_bad = hp_bad + 1;
         hp_seen = 1;
         hp_cnt = 0;
      end
      if (rst_n && tck && (tms !== p_tms || tdi !== p_tdi)) hi_viol = hi_viol + 1;
      p_tck = tck;
      p_tms = tms;
      p_tdi = tdi;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   // one full run with checks; tgt = index of target device (3 = chain B)
   task automatic run_one(input int a, input int b, input int c, input int d,
                          input logic [31:0] eid, input int dv, input int tgt,
                          input bit exp_ok, input bit exp_match, input bit poke);
      int nir, ndr, cyc;
      nir = a + b + 10;
      ndr = c + d + 32;
      @(negedge clk);
      sel_b = (tgt == 3);
      pirt = 8'(a); piri = 8'(b); pdrt = 8'(c); pdri = 8'(d);
      exp_id = eid; div = 8'(dv); dv_cur = dv;
      rise_n = 0; hp_seen = 0; hp_bad = 0; hi_viol = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", 32'(busy), 1);
      if (poke) begin
         repeat (150) @(negedge clk);
         pirt = 8'd3; piri = 8'd4; pdrt = 8'd1; pdri = 8'd2; exp_id = ~eid; div = 8'd7;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 40000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done == 1'b1, "R9 done seen", 32'(done), 1);
      chk(busy == 1'b0, "R9 busy low at done", 32'(busy), 0);
      chk(ir_ok == exp_ok, "R7 ir_ok", 32'(ir_ok), 32'(exp_ok));
      chk(id_match == exp_match, "R6 R8 id_match", 32'(id_match), 32'(exp_match));
      chk(rise_n == 19 + nir + ndr, "R4 rising edge count", 32'(rise_n), 32'(19 + nir + ndr));
      chk(tms_log == 6'b011111, "R2 reset tms pattern", 32'(tms_log), 32'h1f);
      chk(hp_bad == 0, "R5 tck phase length", 32'(hp_bad), 0);
      chk(hi_viol == 0, "R5 tms/tdi moved with tck high", 32'(hi_viol), 0);
      if (tgt == 3) begin
         chk(ir3 == OPC, "R3 target opcode", 32'(ir3), 32'(OPC));
      end else begin
         chk(((tgt == 0) ? ir0 : BYP) == ir0, "R3 d0 opcode", 32'(ir0), 32'((tgt == 0) ? OPC : BYP));
         chk(((tgt == 0) ? OPC : BYP) == ir0, "R3 d0 opcode value", 32'(ir0), 32'((tgt == 0) ? OPC : BYP));
         chk(((tgt == 1) ? OPC : BYP) == ir1, "R3 d1 opcode value", 32'(ir1), 32'((tgt == 1) ? OPC : BYP));
         chk(((tgt == 2) ? OPC : BYP) == ir2, "R3 d2 opcode value", 32'(ir2), 32'((tgt == 2) ? OPC : BYP));
      end
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
      chk(tck == 1'b0, "R5 tck parked", 32'(tck), 0);
   endtask

   task automatic t_reset();
      chk(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
      chk(ir_ok == 0 && id_match == 0, "R1 results after reset", {ir_ok, id_match}, 0);
      chk(tck == 0 && tms == 1, "R1 tck/tms after reset", {tck, tms}, 1);
      repeat (20) @(negedge clk);
      chk(tck == 0, "R1 tck idle low", 32'(tck), 0);
   endtask

   task automatic t_single_min_div();  // R10: div equal to TDO_STAGES
      run_one(0, 0, 0, 0, ID3, 2, 3, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_target_near_tdo();
      run_one(0, 20, 0, 2, ID2, 3, 2, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_target_middle();
      run_one(10, 10, 1, 1, ID1, 2, 1, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_target_near_tdi();
      run_one(20, 0, 2, 0, ID0, 5, 0, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_wrong_id();
      run_one(10, 10, 1, 1, ID1 ^ 32'h8000_0000, 2, 1, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_ir_fault();
      cbad = 4'b0010;
      run_one(10, 10, 1, 1, ID1, 4, 1, 1'b0, 1'b1, 1'b0);
      cbad = '0;
   endtask

   task automatic t_start_while_busy();  // R9: second start ignored
      run_one(0, 20, 0, 2, ID2, 2, 2, 1'b1, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_min_div();
      t_target_near_tdo();
      t_target_middle();
      t_target_near_tdi();
      t_wrong_id();
      t_ir_fault();
      t_start_while_busy();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule